// File: doc/BRIEF.md
# Multichannel DAC Gain-Offset Calibration Engine

This block holds the digital calibration state for a bank of 32 converter channels with 14-bit codes. Each channel keeps a requested code, a 13-bit gain trim and a 14-bit offset trim. From these three values it derives a corrected code: the requested code is scaled by (gain + 1) / 8192, the fraction is dropped, and the offset minus mid-scale (8192) is added. Any result above full scale or below zero is pinned to the nearest end of the code range.

A host loads the trims and requested codes through a single synchronous write port, one register per cycle. The port addresses a channel and a register kind. A load strobe then copies the corrected code of every channel into that channel's output register at the same moment. The output registers drive the converter code bus. Trims are per channel, so each output range can be tuned without touching its neighbours.

Top module: `dac_cal_engine`

## Requirements
- R1: While reset is high and on the cycle after it, every requested code and offset trim is 0x2000 and every gain trim is 0x1FFF. Every output code is 0x2000. A load with these defaults keeps every output at 0x2000.
- R2: A write with `wr_en` high stores data into the register chosen by `wr_sel` of channel `wr_ch` on the next rising edge. The encodings are: 0 = requested code (14 bits), 1 = gain trim (low 13 bits of `wr_data`), 2 = offset trim (14 bits). No other channel's registers change.
- R3: A write with `wr_sel` = 3 changes no register. A following load gives the same outputs as if that write had not happened.
- R4: The corrected code is floor((gain + 1) × code / 8192) + offset − 8192. The product is kept at full precision before the shift.
- R5: A corrected code above 0x3FFF is loaded as 0x3FFF. A code of exactly 0x3FFF is loaded unchanged.
- R6: A corrected code below zero is loaded as 0x0000.
- R7: Output codes change only on a rising edge where `load` is high. All channels update on that same edge, and the new codes are visible right after it.
- R8: A write that is accepted on the same edge as a load is part of that load's result.
- R9: Channel n's output code occupies bits [14n+13:14n] of `dac_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all logic on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_ch | input | 5 | Channel addressed by the write |
| wr_sel | input | 2 | Register kind: 0 code, 1 gain, 2 offset, 3 none |
| wr_data | input | 14 | Write data |
| load | input | 1 | Copies all corrected codes into the output registers |
| dac_code | output | 448 | Output codes, channel n at bits [14n+13:14n] |

## Verification
A corrupted trim or requested code cannot be seen until the next load. At that load it shows up as a wrong code on one 14-bit slice of `dac_code`, one cycle after the strobe. A write that reaches the wrong channel shows only in the two channels involved. For this reason every load in the bench is followed by a comparison of all 32 slices. A stuck or mis-sized clamp shows only when the result is out of range, so random trims push results well past both ends as well as through the middle. Directed cases land exactly on 0x3FFF and on zero.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;

    localparam int CODE_W = 14;
    localparam int GAIN_W = 13;
    localparam int PROD_W = CODE_W + GAIN_W + 1;
    localparam int SUM_W  = CODE_W + 3;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [GAIN_W-1:0] gain_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef enum logic [1:0] {
        SEL_CODE = 2'd0,
        SEL_GAIN = 2'd1,
        SEL_OFFS = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        code_t x1;
        gain_t m;
        code_t c;
    } chan_cfg_t;

    localparam code_t MID_CODE  = code_t'(1 << (CODE_W - 1));
    localparam code_t FULL_CODE = '1;
    localparam gain_t GAIN_RST  = '1;
    localparam chan_cfg_t CFG_RST = '{x1: MID_CODE, m: GAIN_RST, c: MID_CODE};

    // Unclamped corrected code: floor((m+1)*x1 / 2^GAIN_W) + c - mid-scale
    function automatic sum_t cal_sum(chan_cfg_t cfg);
        logic [GAIN_W:0]   g1;
        logic [PROD_W-1:0] prod;
        logic [PROD_W-1:0] shifted;
        g1      = {1'b0, cfg.m} + 1'b1;
        prod    = PROD_W'(g1) * PROD_W'(cfg.x1);
        shifted = prod >> GAIN_W;
        return $signed(SUM_W'(shifted)) + $signed(SUM_W'(cfg.c))
               - $signed(SUM_W'(MID_CODE));
    endfunction

    // Pin the result into the code range
    function automatic code_t clamp_code(sum_t s);
        if (s < 0)
            return '0;
        else if (s > $signed(SUM_W'(FULL_CODE)))
            return FULL_CODE;
        else
            return s[CODE_W-1:0];
    endfunction

endpackage

// File: rtl/dac_cal_regbank.sv
module dac_cal_regbank
    import dac_cal_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  reg_sel_e          wr_sel,
    input  code_t             wr_data,
    output chan_cfg_t         cur_cfg [NUM_CH],
    output chan_cfg_t         nxt_cfg [NUM_CH]
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic      hit;
        chan_cfg_t cfg_q;
        chan_cfg_t cfg_d;

        assign hit = wr_en && (wr_ch == CH_W'(i));

        always_comb begin
            cfg_d = cfg_q;
            if (hit) begin
                case (wr_sel)
                    SEL_CODE: cfg_d.x1 = wr_data;
                    SEL_GAIN: cfg_d.m  = wr_data[GAIN_W-1:0];
                    SEL_OFFS: cfg_d.c  = wr_data;
                    default:  cfg_d    = cfg_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q <= CFG_RST;
            else
                cfg_q <= cfg_d;
        end

        assign cur_cfg[i] = cfg_q;
        assign nxt_cfg[i] = cfg_d;
    end

endmodule

// File: rtl/dac_cal_channel.sv
module dac_cal_channel
    import dac_cal_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  chan_cfg_t cfg,
    output sum_t      raw_sum,
    output code_t     dac_q
);

    code_t clamped;

    assign raw_sum = cal_sum(cfg);
    assign clamped = clamp_code(raw_sum);

    always_ff @(posedge clk) begin
        if (rst)
            dac_q <= MID_CODE;
        else if (load)
            dac_q <= clamped;
    end

endmodule

// File: rtl/dac_cal_engine.sv
module dac_cal_engine
    import dac_cal_pkg::*;
#(
    parameter int NUM_CH  = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BUS_W  = NUM_CH * CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [1:0]         wr_sel,
    input  logic [CODE_W-1:0]  wr_data,
    input  logic               load,
    output logic [BUS_W-1:0]   dac_code
);

    reg_sel_e  sel_e;
    chan_cfg_t cur_cfg [NUM_CH];
    chan_cfg_t nxt_cfg [NUM_CH];
    sum_t      raw_sum [NUM_CH];
    code_t     dac_q   [NUM_CH];

    assign sel_e = reg_sel_e'(wr_sel);

    dac_cal_regbank #(.NUM_CH(NUM_CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_sel  (sel_e),
        .wr_data (wr_data),
        .cur_cfg (cur_cfg),
        .nxt_cfg (nxt_cfg)
    );

    // Channels see the forwarded config so a same-edge write joins the load
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        dac_cal_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .cfg     (nxt_cfg[i]),
            .raw_sum (raw_sum[i]),
            .dac_q   (dac_q[i])
        );
        assign dac_code[i*CODE_W +: CODE_W] = dac_q[i];
    end

endmodule

// File: rtl/dac_cal_checker.sv
module dac_cal_checker
    import dac_cal_pkg::*;
#(
    parameter int NUM_CH  = 32,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int BUS_W  = NUM_CH * CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [CH_W-1:0]    wr_ch,
    input  logic [1:0]         wr_sel,
    input  logic               load,
    input  logic [BUS_W-1:0]   dac_code,
    input  chan_cfg_t          cur_cfg [NUM_CH],
    input  sum_t               raw_sum [NUM_CH]
);

    // R7: outputs hold when no load
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dac_code));

    // R1: reset value on the bus
    p_reset_out_r1: assert property (@(posedge clk)
        rst |=> dac_code == {NUM_CH{MID_CODE}});

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        code_t ch_code;
        assign ch_code = dac_code[i*CODE_W +: CODE_W];

        // R1: reset value of the trims
        p_reset_cfg_r1: assert property (@(posedge clk)
            rst |=> cur_cfg[i] == CFG_RST);

        // R5: overflow pinned to full scale
        p_clamp_hi_r5: assert property (@(posedge clk) disable iff (rst)
            (load && raw_sum[i] > $signed(SUM_W'(FULL_CODE))) |=> ch_code == FULL_CODE);

        // R6: underflow pinned to zero
        p_clamp_lo_r6: assert property (@(posedge clk) disable iff (rst)
            (load && raw_sum[i] < 0) |=> ch_code == '0);

        // R2: write to another channel leaves this one alone
        p_isolate_r2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_ch != CH_W'(i)) |=> $stable(cur_cfg[i]));

        // R3: select value 3 writes nothing
        p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == 2'd3) |=> $stable(cur_cfg[i]));
    end

endmodule

bind dac_cal_engine dac_cal_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_sel   (wr_sel),
    .load     (load),
    .dac_code (dac_code),
    .cur_cfg  (cur_cfg),
    .raw_sum  (raw_sum)
);

// File: tb/dac_cal_engine_tb.sv
module dac_cal_engine_tb;

    localparam int NCH = 32;
    localparam int CW  = 14;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [4:0]       wr_ch = '0;
    logic [1:0]       wr_sel = '0;
    logic [CW-1:0]    wr_data = '0;
    logic             load = 1'b0;
    logic [NCH*CW-1:0] dac_code;

    always #4 clk = ~clk;   // 125 MHz

    dac_cal_engine u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .load     (load),
        .dac_code (dac_code)
    );

    typedef struct {
        int due;
        int ch;
        int exp;
        int req;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int mx1 [NCH];
    int mm  [NCH];
    int mc  [NCH];
    int mdac[NCH];

    always @(posedge clk) cyc <= cyc + 1;

    // Reference transfer: floor((m+1)*x1/8192) + c - 8192, clamped (R4, R5, R6)
    function automatic int ref_code(int x1, int m, int c);
        int s;
        s = (((m + 1) * x1) >>> 13) + c - 8192;
        if (s < 0) s = 0;
        if (s > 16383) s = 16383;
        return s;
    endfunction

    function automatic void apply_write(int ch, int sel, int data);
        case (sel)
            0: mx1[ch] = data & 16'h3FFF;
            1: mm[ch]  = data & 16'h1FFF;
            2: mc[ch]  = data & 16'h3FFF;
            default: ;
        endcase
    endfunction

    function automatic void push_all(int due, int req);
        for (int i = 0; i < NCH; i++) begin
            item_t it;
            it.due = due; it.ch = i; it.exp = mdac[i]; it.req = req;
            q.push_back(it);
        end
    endfunction

    function automatic void model_load();
        for (int i = 0; i < NCH; i++)
            mdac[i] = ref_code(mx1[i], mm[i], mc[i]);
    endfunction

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            int act;
            it = q.pop_front();
            act = int'(dac_code[it.ch*CW +: CW]);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d ch%0d actual %04h expected %04h",
                         it.req, it.ch, act, it.exp);
            end
        end
    end

    // Driver tasks: each is entered just after a falling edge
    task automatic do_write(int ch, int sel, int data);
        wr_en = 1'b1; wr_ch = 5'(ch); wr_sel = 2'(sel); wr_data = CW'(data);
        apply_write(ch, sel, data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_load(int req);
        load = 1'b1;
        model_load();
        push_all(cyc + 1, req);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic do_write_load(int ch, int sel, int data, int req);
        wr_en = 1'b1; wr_ch = 5'(ch); wr_sel = 2'(sel); wr_data = CW'(data);
        load = 1'b1;
        apply_write(ch, sel, data);
        model_load();
        push_all(cyc + 1, req);
        @(negedge clk);
        wr_en = 1'b0; load = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin
            mx1[i] = 16'h2000; mm[i] = 16'h1FFF; mc[i] = 16'h2000; mdac[i] = 16'h2000;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset outputs, then a load with default trims
        push_all(cyc, 1);
        @(negedge clk);
        do_load(1);

        // R4: half gain with small positive offset on ch3 -> 2064
        do_write(3, 0, 16'h1000);
        do_write(3, 1, 16'h0FFF);
        do_write(3, 2, 16'h2010);
        // R5: overflow on ch7; exact full scale on ch9
        do_write(7, 0, 16'h3FFF);
        do_write(7, 2, 16'h3FFF);
        do_write(9, 0, 16'h3FFF);
        // R6: underflow on ch8
        do_write(8, 0, 16'h0000);
        do_write(8, 2, 16'h0000);
        do_load(4);

        // R9: distinct codes on every channel show each slice in place
        for (int i = 0; i < NCH; i++) do_write(i, 0, 16'h0100 * i + i);
        do_load(9);

        // R3: select 3 must change nothing
        do_write(3, 3, 16'h0000);
        do_write(12, 3, 16'h3FFF);
        do_load(3);

        // R7: write without load leaves outputs; then the load applies it
        do_write(10, 0, 16'h0123);
        do_write(10, 2, 16'h1000);
        push_all(cyc, 7);
        repeat (2) @(negedge clk);
        push_all(cyc, 7);
        @(negedge clk);
        do_load(7);

        // R8: write on the same edge as load is included
        do_write_load(11, 0, 16'h0100, 8);
        do_write_load(11, 1, 16'h0000, 8);

        // R2: gain write to ch0 only, all others unchanged
        do_write(0, 1, 16'h3ABC);
        do_load(2);

        // R4/R5/R6: random sweep over full trim ranges
        for (int k = 0; k < 40; k++) begin
            for (int w = 0; w < 4; w++)
                do_write(int'($urandom_range(NCH - 1)), int'($urandom_range(2)),
                         int'($urandom_range(16'h3FFF)));
            do_load(4);
        end

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected finished");
            finish_run();
        end
    end

endmodule